// File: doc/BRIEF.md
# Dual-Master Bus Ownership and Interrupt Controller

This block decides which of two upstream bus masters is currently connected to a shared downstream bus, and it raises per-master active-low interrupt lines. Each master can request the bus or give it up through abstract register writes. When a master requests the bus, it takes ownership at once, whether the current holder is still working or has failed. If both masters request in the same cycle, channel 0 wins. The master that is no longer connected cannot affect the downstream side, because the connection vector never names more than one channel.

Optionally, a switch can pass through a recovery phase of a parameterised number of cycles. During that phase no channel is connected, and at its end the new owner receives a completion notice. The master that lost the bus always receives a loss notice. A downstream active-low interrupt is forwarded to both masters as a level. Each master has its own mask for loss notices, completion notices and forwarding. Notices are held in flags that the master clears by writing a 1. A parameter chosen at build time sets whether channel 0 or no channel is connected after reset. Either the external reset or the power-on reset returns every register to its default.

Top module: `dual_master_irq_ctrl`

## Requirements
- R1: `conn` bit i set means channel i (0 or 1) is connected; at most one bit of `conn` is ever set.
- R2: After reset, `conn` is 2'b01 when RESET_CH0 is 1 and 2'b00 when it is 0. After reset all notice flags are clear, all mask bits are 0, `recov_busy` is 0 and `irq_n` is 2'b11 while `dn_int_n` is high.
- R3: With `recov_en` low, a `grab_req` bit i for a master that is not the holder makes `conn` equal to the one-hot of i right after the next clock edge. A request from the current holder changes nothing.
- R4: If both `grab_req` bits are set in one cycle, channel 0 wins. A grab in a cycle takes precedence over any `rel_req` in the same cycle.
- R5: A `rel_req` bit from the holder disconnects it (`conn` becomes 2'b00) and raises no notice. A `rel_req` bit from the master that is not the holder is ignored.
- R6: When ownership moves away from master i, its loss flag is set and `irq_n[i]` goes low.
- R7: With `recov_en` high, a switch drives `conn` to 2'b00 and `recov_busy` high for RECOV_CYCLES clock edges. The new owner is then connected, its completion flag is set and its `irq_n` goes low.
- R8: While `dn_int_n` is low, `irq_n[i]` is low for every master i whose forward mask is 0.
- R9: Per master i, `mask_wdata[3i+0]` masks loss notices, `[3i+1]` masks completion notices and `[3i+2]` masks forwarding; a write is made by `mask_wr[i]`. A masked source never drives `irq_n` low, and an event that occurs while it is masked is not latched.
- R10: Writing `clr_wr[i]` with `clr_wdata[2i+0]` (loss) or `clr_wdata[2i+1]` (completion) set clears that flag. A flag being set in the same cycle wins over the clear.
- R11: Driving either `rst_n` or `por_n` low for one clock edge restores the state required by R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| por_n | input | 1 | Synchronous active-low power-on reset |
| recov_en | input | 1 | Insert the recovery phase on each switch |
| grab_req | input | 2 | Per-master bus request pulse |
| rel_req | input | 2 | Per-master bus release pulse |
| mask_wr | input | 2 | Per-master mask register write strobe |
| mask_wdata | input | 6 | Mask write data, 3 bits per master |
| clr_wr | input | 2 | Per-master flag clear strobe |
| clr_wdata | input | 4 | Write-1-to-clear data, 2 bits per master |
| dn_int_n | input | 1 | Active-low downstream interrupt |
| conn | output | 2 | One-hot-or-zero connected channel |
| recov_busy | output | 1 | Recovery phase in progress |
| irq_n | output | 2 | Per-master active-low interrupt |

## Verification
The bench sweeps all eight mask codes for both masters. For each code it causes a direct switch, with the downstream interrupt first idle and then active, and it then repeats the switch with recovery enabled. This separates the loss, completion and forwarding mask bits from one another and shows that a masked event is not latched. Directed patterns cover simultaneous requests, a grab that coincides with a release, releases from the holder and from the non-holder, and a clear that coincides with a flag being set. A second instance, built with no channel connected at reset, shows the other reset option. Both reset inputs are pulsed after the masks have been changed.

// File: rtl/msel_pkg.sv
// Shared definitions for the dual-master selector interrupt controller.
// Assumes exactly two upstream masters; field indexes are fixed here.
package msel_pkg;
    localparam int NCH     = 2;
    localparam int ID_W    = 1;
    // mask field positions inside one master's mask word
    localparam int MSK_LOST = 0;
    localparam int MSK_DONE = 1;
    localparam int MSK_FWD  = 2;
    localparam int MSK_W    = 3;
    // flag field positions inside one master's clear word
    localparam int FLG_LOST = 0;
    localparam int FLG_DONE = 1;
    localparam int FLG_W    = 2;

    typedef enum logic [1:0] {
        OWN_IDLE  = 2'd0,
        OWN_HELD  = 2'd1,
        OWN_RECOV = 2'd2
    } own_state_t;
endpackage

// File: rtl/msel_arbiter.sv
// Request arbiter: picks a grab winner (channel 0 first) and decides whether
// a release from the current holder applies. Purely combinational; assumes
// the holder information comes from msel_owner in the same cycle.
module msel_arbiter
    import msel_pkg::*;
(
    input  logic [NCH-1:0]  grab_req,
    input  logic [NCH-1:0]  rel_req,
    input  logic            holder_vld,
    input  logic [ID_W-1:0] holder_id,
    output logic            grab_vld,
    output logic [ID_W-1:0] grab_id,
    output logic            rel_hit
);
    // Fixed priority: lowest channel index wins; a grab outranks a release.
    always_comb begin
        grab_vld = |grab_req;
        grab_id  = grab_req[0] ? 1'b0 : 1'b1;
        rel_hit  = !grab_vld && holder_vld && rel_req[holder_id];
    end
endmodule

// File: rtl/msel_owner.sv
// Ownership state machine: tracks the holder, runs the optional recovery
// countdown and emits one-cycle loss and completion events per master.
// Assumes RECOV_CYCLES >= 1 and a synchronous active-low reset.
module msel_owner
    import msel_pkg::*;
#(
    parameter bit RESET_CH0    = 1'b1,
    parameter int RECOV_CYCLES = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            recov_en,
    input  logic            grab_vld,
    input  logic [ID_W-1:0] grab_id,
    input  logic            rel_hit,
    output logic            holder_vld,
    output logic [ID_W-1:0] holder_id,
    output logic            busy,
    output logic [NCH-1:0]  conn_o,
    output logic [NCH-1:0]  lost_evt,
    output logic [NCH-1:0]  done_evt
);
    localparam int CNT_W = (RECOV_CYCLES > 1) ? $clog2(RECOV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RECOV_CYCLES - 1);

    own_state_t       state_q;
    logic [ID_W-1:0]  id_q;
    logic [CNT_W-1:0] cnt_q;
    logic             switch_c;

    // Decode holder view and the switch condition for the current cycle.
    always_comb begin
        holder_vld = (state_q != OWN_IDLE);
        holder_id  = id_q;
        busy       = (state_q == OWN_RECOV);
        switch_c   = grab_vld && (!holder_vld || (grab_id != id_q));
    end

    // Per-channel connection and event decode.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_comb begin
            conn_o[i]   = (state_q == OWN_HELD) && (id_q == ID_W'(i));
            lost_evt[i] = switch_c && holder_vld && (id_q == ID_W'(i));
            done_evt[i] = busy && (cnt_q == '0) && !switch_c && !rel_hit
                          && (id_q == ID_W'(i));
        end
    end

    // Holder, recovery countdown and state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_CH0 ? OWN_HELD : OWN_IDLE;
            id_q    <= '0;
            cnt_q   <= '0;
        end else if (switch_c) begin
            state_q <= recov_en ? OWN_RECOV : OWN_HELD;
            id_q    <= grab_id;
            cnt_q   <= CNT_LOAD;
        end else if (rel_hit) begin
            state_q <= OWN_IDLE;
            cnt_q   <= '0;
        end else if (busy) begin
            if (cnt_q == '0) state_q <= OWN_HELD;
            else             cnt_q   <= cnt_q - 1'b1;
        end
    end

    // R1
    conn_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(conn_o));

    // R7
    recov_connect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_evt) |=> (conn_o == $past(done_evt)));

    // R3
    conn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(conn_o)) |-> $past(grab_vld || rel_hit || busy));
endmodule

// File: rtl/msel_irq_side.sv
// One master's interrupt side: mask register, loss and completion flags with
// write-1-to-clear, and the active-low output combining them with the
// forwarded downstream interrupt. A set event outranks a clear.
module msel_irq_side
    import msel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr,
    input  logic [MSK_W-1:0] mask_wdata,
    input  logic             clr_wr,
    input  logic [FLG_W-1:0] clr_wdata,
    input  logic             lost_evt,
    input  logic             done_evt,
    input  logic             dn_int_n,
    output logic             irq_n
);
    logic [MSK_W-1:0] mask_q;
    logic [FLG_W-1:0] flag_q;
    logic [FLG_W-1:0] set_c;
    logic [FLG_W-1:0] clr_c;

    // Event qualification by the mask in force when the event occurs.
    always_comb begin
        set_c[FLG_LOST] = lost_evt && !mask_q[MSK_LOST];
        set_c[FLG_DONE] = done_evt && !mask_q[MSK_DONE];
        clr_c           = clr_wr ? clr_wdata : '0;
    end

    // Mask register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    // Flag register: set wins over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= set_c | (flag_q & ~clr_c);
    end

    // Active-low output from unmasked flags and forwarded interrupt.
    always_comb begin
        irq_n = !((flag_q[FLG_LOST] && !mask_q[MSK_LOST])
               || (flag_q[FLG_DONE] && !mask_q[MSK_DONE])
               || (!dn_int_n && !mask_q[MSK_FWD]));
    end

    // R6
    lost_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_evt && !mask_q[MSK_LOST]) |=> flag_q[FLG_LOST]);

    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q[FLG_LOST] && mask_q[MSK_LOST]) |=> !flag_q[FLG_LOST]);

    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_wdata[FLG_DONE] && !done_evt) |=> !flag_q[FLG_DONE]);
endmodule

// File: rtl/dual_master_irq_ctrl.sv
// Top of the dual-master selector interrupt controller. Combines the two
// reset inputs into one synchronous reset, arbitrates requests, keeps the
// ownership state and instantiates one interrupt side per master.
// Assumes all request, write and clear inputs are single-cycle pulses.
module dual_master_irq_ctrl
    import msel_pkg::*;
#(
    parameter bit RESET_CH0    = 1'b1,
    parameter int RECOV_CYCLES = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  por_n,
    input  logic                  recov_en,
    input  logic [1:0]            grab_req,
    input  logic [1:0]            rel_req,
    input  logic [1:0]            mask_wr,
    input  logic [5:0]            mask_wdata,
    input  logic [1:0]            clr_wr,
    input  logic [3:0]            clr_wdata,
    input  logic                  dn_int_n,
    output logic [1:0]            conn,
    output logic                  recov_busy,
    output logic [1:0]            irq_n
);
    logic            rst_all_n;
    logic            holder_vld;
    logic [ID_W-1:0] holder_id;
    logic            grab_vld;
    logic [ID_W-1:0] grab_id;
    logic            rel_hit;
    logic [NCH-1:0]  lost_evt;
    logic [NCH-1:0]  done_evt;

    // Either reset source resets the whole block.
    always_comb rst_all_n = rst_n && por_n;

    msel_arbiter u_arb (
        .grab_req   (grab_req),
        .rel_req    (rel_req),
        .holder_vld (holder_vld),
        .holder_id  (holder_id),
        .grab_vld   (grab_vld),
        .grab_id    (grab_id),
        .rel_hit    (rel_hit)
    );

    msel_owner #(
        .RESET_CH0    (RESET_CH0),
        .RECOV_CYCLES (RECOV_CYCLES)
    ) u_own (
        .clk        (clk),
        .rst_n      (rst_all_n),
        .recov_en   (recov_en),
        .grab_vld   (grab_vld),
        .grab_id    (grab_id),
        .rel_hit    (rel_hit),
        .holder_vld (holder_vld),
        .holder_id  (holder_id),
        .busy       (recov_busy),
        .conn_o     (conn),
        .lost_evt   (lost_evt),
        .done_evt   (done_evt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_side
        msel_irq_side u_side (
            .clk        (clk),
            .rst_n      (rst_all_n),
            .mask_wr    (mask_wr[i]),
            .mask_wdata (mask_wdata[MSK_W*i +: MSK_W]),
            .clr_wr     (clr_wr[i]),
            .clr_wdata  (clr_wdata[FLG_W*i +: FLG_W]),
            .lost_evt   (lost_evt[i]),
            .done_evt   (done_evt[i]),
            .dn_int_n   (dn_int_n),
            .irq_n      (irq_n[i])
        );
    end

    // R4
    grab_prio_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
        (grab_req == 2'b11 && !recov_en) |=> (conn == 2'b01));
endmodule

// File: tb/dual_master_irq_ctrl_tb.sv
module dual_master_irq_ctrl_tb;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, por_n = 1'b0, recov_en = 1'b0, dn_int_n = 1'b1;
    logic [1:0] grab_req = '0, rel_req = '0, mask_wr = '0, clr_wr = '0;
    logic [5:0] mask_wdata = '0;
    logic [3:0] clr_wdata = '0;
    logic [1:0] conn, irq_n, conn_nc, irq_nc;
    logic       recov_busy, busy_nc;
    int n_cmp = 0, n_bad = 0;
    bit fin = 0;
    int h;

    always #2 clk = ~clk;

    dual_master_irq_ctrl #(.RESET_CH0(1'b1), .RECOV_CYCLES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .recov_en(recov_en),
        .grab_req(grab_req), .rel_req(rel_req), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .dn_int_n(dn_int_n), .conn(conn), .recov_busy(recov_busy), .irq_n(irq_n));

    dual_master_irq_ctrl #(.RESET_CH0(1'b0), .RECOV_CYCLES(N)) u_dut_nc (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .recov_en(recov_en),
        .grab_req(grab_req), .rel_req(rel_req), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .dn_int_n(dn_int_n), .conn(conn_nc), .recov_busy(busy_nc), .irq_n(irq_nc));

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_wr = 2'b11; clr_wdata = 4'b1111; step(); clr_wr = '0; clr_wdata = '0;
    endtask

    task automatic grab(logic [1:0] v);
        grab_req = v; step(); grab_req = '0;
    endtask

    initial begin
        #400000;
        if (!fin) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        rst_n = 1'b1; por_n = 1'b1; step();
        // R2 reset state, both build options
        chk("R2 conn ch0 build", {6'd0, conn}, 8'h01);
        chk("R2 conn none build", {6'd0, conn_nc}, 8'h00);
        chk("R2 irq idle", {6'd0, irq_n}, 8'h03);
        chk("R2 busy", {7'd0, recov_busy}, 8'h00);
        // R4 simultaneous grabs: channel 0 wins
        grab(2'b11);
        chk("R4 both grab held", {6'd0, conn}, 8'h01);
        chk("R4 both grab from idle", {6'd0, conn_nc}, 8'h01);
        chk("R3 holder regrab no notice", {6'd0, irq_n}, 8'h03);
        // R3 / R6 switch to master 1
        grab(2'b10);
        chk("R3 switch to 1", {6'd0, conn}, 8'h02);
        chk("R6 loss to 0", {6'd0, irq_n}, 8'h02);
        // R10 clear loss of master 0
        clr_wr = 2'b01; clr_wdata = 4'b0001; step(); clr_wr = '0; clr_wdata = '0;
        chk("R10 w1c clear", {6'd0, irq_n}, 8'h03);
        // R5 release from non-holder ignored, from holder disconnects
        rel_req = 2'b01; step(); rel_req = '0;
        chk("R5 non-holder release", {6'd0, conn}, 8'h02);
        rel_req = 2'b10; step(); rel_req = '0;
        chk("R5 holder release", {6'd0, conn}, 8'h00);
        chk("R5 release no notice", {6'd0, irq_n}, 8'h03);
        // R4 grab beats release in same cycle
        grab(2'b01);
        grab_req = 2'b10; rel_req = 2'b01; step(); grab_req = '0; rel_req = '0;
        chk("R4 grab beats release", {6'd0, conn}, 8'h02);
        chk("R4 loss on preempt", {6'd0, irq_n}, 8'h02);
        clear_all();
        h = 1;
        // R9 / R8 / R6 sweep of all mask codes, direct switching
        for (int m = 0; m < 8; m++) begin
            logic [1:0] e;
            int o;
            mask_wr = 2'b11; mask_wdata = {m[2:0], m[2:0]};
            clr_wr = 2'b11; clr_wdata = 4'b1111;
            step();
            mask_wr = '0; clr_wr = '0; clr_wdata = '0;
            o = h; h = 1 - h;
            grab(h == 0 ? 2'b01 : 2'b10);
            chk($sformatf("R3 sweep conn m=%0d", m), {6'd0, conn}, 8'(1 << h));
            e = 2'b11; e[o] = m[0];
            chk($sformatf("R6 R9 loss m=%0d", m), {6'd0, irq_n}, {6'd0, e});
            dn_int_n = 1'b0; #1;
            e = 2'b11; e[o] = m[0] & m[2]; e[h] = m[2];
            chk($sformatf("R8 forward m=%0d", m), {6'd0, irq_n}, {6'd0, e});
            dn_int_n = 1'b1;
            if (m[0]) begin
                mask_wr = 2'b11; mask_wdata = '0; step(); mask_wr = '0;
                chk($sformatf("R9 masked not latched m=%0d", m), {6'd0, irq_n}, 8'h03);
            end
        end
        // R7 recovery sweep
        recov_en = 1'b1;
        for (int m = 0; m < 8; m++) begin
            logic [1:0] e;
            int o;
            mask_wr = 2'b11; mask_wdata = {m[2:0], m[2:0]};
            clr_wr = 2'b11; clr_wdata = 4'b1111;
            step();
            mask_wr = '0; clr_wr = '0; clr_wdata = '0;
            o = h; h = 1 - h;
            grab(h == 0 ? 2'b01 : 2'b10);
            for (int j = 1; j < N; j++) begin
                chk($sformatf("R7 isolated m=%0d j=%0d", m, j), {5'd0, recov_busy, conn}, 8'h04);
                step();
            end
            chk($sformatf("R7 still isolated m=%0d", m), {6'd0, conn}, 8'h00);
            step();
            chk($sformatf("R7 connected m=%0d", m), {5'd0, recov_busy, conn}, 8'(1 << h));
            e = 2'b11; e[o] = m[0]; e[h] = m[1];
            chk($sformatf("R7 R9 notices m=%0d", m), {6'd0, irq_n}, {6'd0, e});
        end
        recov_en = 1'b0;
        // R10 set beats clear
        mask_wr = 2'b11; mask_wdata = '0; step(); mask_wr = '0;
        clear_all();
        o_blk: begin
            int o;
            o = h; h = 1 - h;
            grab_req = (h == 0) ? 2'b01 : 2'b10;
            clr_wr = 2'b11; clr_wdata = 4'b0101;
            step();
            grab_req = '0; clr_wr = '0; clr_wdata = '0;
            chk("R10 set beats clear", {6'd0, irq_n}, (o == 0) ? 8'h02 : 8'h01);
        end
        // R11 external reset
        if (h == 0) grab(2'b10);
        mask_wr = 2'b11; mask_wdata = 6'h3F; step(); mask_wr = '0;
        rst_n = 1'b0; step(); rst_n = 1'b1;
        dn_int_n = 1'b0; #1;
        chk("R11 rst_n conn", {6'd0, conn}, 8'h01);
        chk("R11 rst_n masks cleared", {6'd0, irq_n}, 8'h00);
        dn_int_n = 1'b1; #1;
        chk("R11 rst_n flags cleared", {6'd0, irq_n}, 8'h03);
        // R11 power-on reset
        grab(2'b10);
        mask_wr = 2'b11; mask_wdata = 6'h3F; step(); mask_wr = '0;
        por_n = 1'b0; step(); por_n = 1'b1;
        dn_int_n = 1'b0; #1;
        chk("R11 por_n conn", {6'd0, conn}, 8'h01);
        chk("R11 por_n conn none build", {6'd0, conn_nc}, 8'h00);
        chk("R11 por_n masks cleared", {6'd0, irq_n}, 8'h00);
        dn_int_n = 1'b1;
        step();
        fin = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule